// File: doc/BRIEF.md
# Host Controller Software Reset Sequencer

This unit owns the three self-clearing software reset bits of a storage host controller. Software writes the reset field. Each bit that is written to 1 starts a reset sequence. The sequence sends a one-cycle clear strobe to the part of the controller that the bit governs. The bit then reads back as 1 until the sequence ends, and after that it returns to 0 by itself.

The widest of the three resets covers every software-visible register bit of the controller except the card-detection logic. The command-line reset clears the command-busy flag and the command-done status. The data-line reset covers the buffer and its data port, the DMA engine, the transfer-active, line-active and data-busy flags, the block-gap continue and stop requests, and the data-side interrupt status bits.

Completion is delayed by a parameterised number of cycles (`DELAY`). This delay stands in for gated clocks, so software may have to poll a bit several times before it drops. The full reset also waits until the capability registers are reported valid.

Each bit runs its own lane state machine with four states:
- `SR_IDLE`: the bit reads 0.
- `SR_PULSE`: one cycle in which the clear strobe is issued.
- `SR_HOLD`: `DELAY` cycles of simulated gating delay.
- `SR_CAPS`: used by the full reset only. It waits for the capability-valid indication.

The transitions are:
- IDLE→PULSE on an accepted write of 1.
- PULSE→HOLD always.
- HOLD→IDLE (line lanes) or HOLD→CAPS (full lane) when the delay counter reaches zero.
- CAPS→IDLE when capability-valid is sampled high.
- Any state→IDLE on an abort. Only the line lanes can be aborted, and only by the start of a full reset.

Top module: `swrst_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, all three reset bits read 0 and all clear strobes are 0.
- R2: Field bit 0 is the full reset, bit 1 the command-line reset and bit 2 the data-line reset (1 = resetting, 0 = normal). A write with a 1 in an idle bit makes that bit read 1 from the clock edge that accepts the write.
- R3: Starting a command-line reset raises `clr_cmd_o` for exactly one cycle, the first cycle in which the bit reads 1. Starting a data-line reset does the same on `clr_dat_o`.
- R4: Starting a full reset raises `clr_all_o`, `clr_cmd_o` and `clr_dat_o` together for exactly one cycle. In that cycle the reset field reads 3'b001.
- R5: A line reset bit reads 1 for exactly 1+`DELAY` cycles and then returns to 0 by itself.
- R6: The full reset bit reads 1 for at least 2+`DELAY` cycles. After its delay it stays 1 until `caps_valid_i` is sampled high, and it clears at that edge.
- R7: Writing 0 to a bit that is resetting has no effect. Writing 1 again to it neither restarts the sequence nor issues another strobe, so the bit's duration is unchanged.
- R8: Starting a full reset returns any in-progress line reset bit to 0 at once. Line reset writes are ignored while the full reset is in progress or being started.
- R9: The command-line and data-line resets are independent. Both may be started by the same write and then run concurrently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the reset field |
| wr_data_i | input | 3 | Data written to the reset field |
| caps_valid_i | input | 1 | Capability registers are valid to read |
| rst_bits_o | output | 3 | Readable reset field |
| clr_all_o | output | 1 | Full-controller clear strobe (card detect excluded) |
| clr_cmd_o | output | 1 | Command-side clear strobe |
| clr_dat_o | output | 1 | Data-side, buffer and DMA clear strobe |

## Verification
The bench polls the reset field every cycle through each bit's full duration. An off-by-one in the delay counter therefore shows up as a bit that drops one poll early or late. It holds `caps_valid_i` low past the delay, which exposes a full reset that clears without waiting for the capability registers. It rewrites 0 and then 1 into a command reset in progress; a design that aborts or restarts the sequence would drop the bit early, stretch it, or pulse the strobe a second time. It also launches a full reset over two running line resets and then writes the line bits during it. A design that failed to cancel them, or that accepted those writes, would show line bits at 1 or stray line strobes.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_PULSE = 2'd1,
        SR_HOLD  = 2'd2,
        SR_CAPS  = 2'd3
    } sr_state_e;

    localparam int unsigned NUM_LANES = 3;
    localparam int unsigned LANE_ALL  = 0;
    localparam int unsigned LANE_CMD  = 1;
    localparam int unsigned LANE_DAT  = 2;
endpackage

// File: rtl/swrst_lane.sv
module swrst_lane
    import swrst_pkg::*;
#(
    parameter int unsigned DELAY      = 4,
    parameter bit          NEEDS_CAPS = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic abort_i,
    input  logic caps_ok_i,
    output logic busy_o,
    output logic strobe_o
);
    localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(DELAY - 1);

    sr_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SR_IDLE: begin
                if (start_i) state_d = SR_PULSE;
            end
            SR_PULSE: begin
                state_d = SR_HOLD;
                cnt_d   = CNT_LOAD;
            end
            SR_HOLD: begin
                if (cnt_q == '0) state_d = NEEDS_CAPS ? SR_CAPS : SR_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            SR_CAPS: begin
                if (caps_ok_i) state_d = SR_IDLE;
            end
            default: state_d = SR_IDLE;
        endcase
        if (abort_i) state_d = SR_IDLE;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy_o   = 1'b0;
        strobe_o = 1'b0;
        unique case (state_q)
            SR_IDLE:  busy_o = 1'b0;
            SR_PULSE: begin
                busy_o   = 1'b1;
                strobe_o = 1'b1;
            end
            SR_HOLD:  busy_o = 1'b1;
            SR_CAPS:  busy_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    // R3
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> !strobe_o);

    // R7
    hold_no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SR_HOLD && cnt_q != '0 && !abort_i) |=> busy_o);

    generate
        if (NEEDS_CAPS) begin : g_caps_chk
            // R6
            caps_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $fell(busy_o) |-> $past(caps_ok_i));
        end
    endgenerate
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
    import swrst_pkg::*;
#(
    parameter int unsigned DELAY = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [2:0] wr_data_i,
    input  logic       caps_valid_i,
    output logic [2:0] rst_bits_o,
    output logic       clr_all_o,
    output logic       clr_cmd_o,
    output logic       clr_dat_o
);
    logic [NUM_LANES-1:0] start;
    logic [NUM_LANES-1:0] abort;
    logic [NUM_LANES-1:0] busy;
    logic [NUM_LANES-1:0] strobe;

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            if (i == LANE_ALL) begin : g_full
                assign start[i] = wr_en_i & wr_data_i[i] & ~busy[i];
                assign abort[i] = 1'b0;
            end else begin : g_line
                assign start[i] = wr_en_i & wr_data_i[i] & ~busy[i]
                                  & ~busy[LANE_ALL] & ~start[LANE_ALL];
                assign abort[i] = start[LANE_ALL];
            end

            swrst_lane #(
                .DELAY      (DELAY),
                .NEEDS_CAPS (i == LANE_ALL)
            ) u_lane (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .start_i   (start[i]),
                .abort_i   (abort[i]),
                .caps_ok_i (caps_valid_i),
                .busy_o    (busy[i]),
                .strobe_o  (strobe[i])
            );
        end
    endgenerate

    assign rst_bits_o = busy;
    assign clr_all_o  = strobe[LANE_ALL];
    assign clr_cmd_o  = strobe[LANE_ALL] | strobe[LANE_CMD];
    assign clr_dat_o  = strobe[LANE_ALL] | strobe[LANE_DAT];

    // R4
    full_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_all_o |-> (rst_bits_o == 3'b001));

    // R8
    line_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_bits_o[LANE_ALL] |=> !$rose(rst_bits_o[LANE_CMD]) && !$rose(rst_bits_o[LANE_DAT]));

    // R2
    cmd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_bits_o[LANE_CMD]) |-> clr_cmd_o);

    // R2
    dat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_bits_o[LANE_DAT]) |-> clr_dat_o);
endmodule

// File: tb/swrst_ctrl_tb.sv
`timescale 1ns/1ps
module swrst_ctrl_tb;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic       caps = 1'b0;
    logic [2:0] bits;
    logic       c_all, c_cmd, c_dat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    swrst_ctrl #(.DELAY(D)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .caps_valid_i (caps),
        .rst_bits_o   (bits),
        .clr_all_o    (c_all),
        .clr_cmd_o    (c_cmd),
        .clr_dat_o    (c_dat)
    );

    // monitor: {bits, clr_all, clr_cmd, clr_dat}
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({bits, c_all, c_cmd, c_dat} !== e) begin
                errors++;
                $display("FAIL %s: got %b expected %b", t,
                         {bits, c_all, c_cmd, c_dat}, e);
            end
        end
    end

    // driver: one cycle of stimulus plus the expected outputs after that edge
    task automatic step(input logic w, input logic [2:0] d, input logic cv,
                        input logic [5:0] e, input string t);
        @(negedge clk);
        wr_en = w;
        wr_data = d;
        caps = cv;
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle(input int n, input logic cv, input logic [5:0] e, input string t);
        for (int k = 0; k < n; k++) step(1'b0, 3'b000, cv, e, t);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        checks++;  // R1 during reset
        if ({bits, c_all, c_cmd, c_dat} !== 6'b000_000) begin
            errors++;
            $display("FAIL R1: got %b expected %b", {bits, c_all, c_cmd, c_dat}, 6'b0);
        end
        rst_n = 1'b1;
        idle(2, 1'b0, 6'b000_000, "R1");

        // command-line reset: R2 R3 R5
        step(1'b1, 3'b010, 1'b0, 6'b010_010, "R3 cmd strobe");
        idle(D, 1'b0, 6'b010_000, "R5 cmd hold");
        idle(1, 1'b0, 6'b000_000, "R5 cmd self-clear");

        // data-line reset: R2 R3 R5
        step(1'b1, 3'b100, 1'b0, 6'b100_001, "R3 dat strobe");
        idle(D, 1'b0, 6'b100_000, "R5 dat hold");
        idle(1, 1'b0, 6'b000_000, "R5 dat self-clear");

        // full reset waiting on caps: R4 R6
        step(1'b1, 3'b001, 1'b0, 6'b001_111, "R4 full strobes");
        idle(D, 1'b0, 6'b001_000, "R6 full hold");
        idle(3, 1'b0, 6'b001_000, "R6 waiting caps");
        idle(1, 1'b1, 6'b000_000, "R6 clear on caps");

        // writes during a command reset: R7
        step(1'b1, 3'b010, 1'b0, 6'b010_010, "R7 start");
        step(1'b1, 3'b000, 1'b0, 6'b010_000, "R7 write 0 ignored");
        step(1'b1, 3'b010, 1'b0, 6'b010_000, "R7 rewrite 1 no restart");
        idle(D - 2, 1'b0, 6'b010_000, "R7 hold");
        idle(1, 1'b0, 6'b000_000, "R7 duration unchanged");

        // concurrent lines then full reset over them: R9 R8
        step(1'b1, 3'b110, 1'b0, 6'b110_011, "R9 both lines");
        idle(1, 1'b0, 6'b110_000, "R9 both hold");
        step(1'b1, 3'b001, 1'b1, 6'b001_111, "R8 full cancels lines");
        step(1'b1, 3'b110, 1'b1, 6'b001_000, "R8 line write ignored");
        idle(D - 1, 1'b1, 6'b001_000, "R8 full hold");
        idle(1, 1'b1, 6'b001_000, "R6 caps stage");
        idle(1, 1'b1, 6'b000_000, "R6 full done");
        idle(1, 1'b0, 6'b000_000, "R8 no line started");

        // full and command in one write: R8
        step(1'b1, 3'b011, 1'b1, 6'b001_111, "R8 same-write line ignored");
        idle(D + 1, 1'b1, 6'b001_000, "R6 hold to caps");
        idle(1, 1'b1, 6'b000_000, "R6 done");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule